// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block connects internal parallel voice samples to a framed time-division serial bus. A bit clock and an 8 kHz short-frame sync pulse define the frame. The bus is cut into slots, and the host chooses the slot width. An 8-bit companded sample uses 8-bit slots, which gives 32 slots in a 256-bit frame. A 16-bit linear sample uses 16-bit slots, which gives 16 slots. The host places two receive channels and one transmit channel on slot numbers of its choice, and each placement is independent of the others.

Every serial sample travels most significant bit first. The block samples the serial input on the falling edge of the bit clock and changes the serial output after the rising edge. It drives the output only during its own transmit slot and signals this with an output-enable line. At all other times the pad can be left tri-stated. Each receive channel presents its assembled sample on a parallel output together with a one-cycle ready strobe. The transmit sample is captured at the start of each frame.

The block can take the bit clock and sync from outside. It can also produce them itself from the system clock, with a fixed 256-bit frame, so that the system clock divides down to 2.048 MHz. Power-down clears all state and holds the generated clock outputs low.

Top module: `pcm_tdm_port`

## Requirements
- R1: While reset is asserted, serOut, serOe, rxReadyA, rxReadyB, bclkOut and syncOut are 0, and rxDataA and rxDataB are 0.
- R2: The sync level is sampled on each falling bit-clock edge. The bit period that begins at the next rising edge is bit 0 of a new frame. Every sync restarts the bit count, so frames of any length up to 256 bits are accepted. Before the first sync after reset or power-down, serOe stays 0 and no ready strobe occurs.
- R3: With linearMode=0, slot n occupies bits 8n to 8n+7, and slot numbers 0 to 31 are valid.
- R4: With linearMode=1, slot n occupies bits 16n to 16n+15, and slot numbers 0 to 15 are valid. A slot number of 16 to 31 never matches, so it produces no strobe and no output enable.
- R5: A received sample is assembled MSB first, with the first bit of the slot as the MSB. With linearMode=0 the 8-bit code appears in rxData[7:0] and bits [15:8] are 0.
- R6: Each receive channel pulses its ready output high for exactly one system clock per completed slot. The new sample is valid on rxData in that same cycle, and rxData holds its value at all other times.
- R7: The two receive channels are independent. If both are set to the same slot, both strobe in the same cycle with the same sample.
- R8: serOe is 1 for exactly the bit periods of the transmit slot. During those periods serOut carries the sample MSB first: txSample[7:0] with linearMode=0, or txSample[15:0] with linearMode=1. serOut is 0 whenever serOe is 0.
- R9: txSample is captured at the first rising edge of each frame. A change to txSample later in the frame has no effect on the bits sent in that frame.
- R10: With masterMode=1, bclkOut toggles every HALF_DIV system clocks. syncOut goes high together with a rising bclkOut, stays high for one bit period and repeats every 256 bit periods. The internal framing then follows these generated signals. With masterMode=0, bclkOut and syncOut are 0.
- R11: While powerDown is 1, bclkOut, syncOut, serOe and both ready strobes are 0, and rxDataA and rxDataB are cleared to 0. After release, the block waits for a new sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerDown | input | 1 | Power-down: clears state, holds clock outputs low |
| masterMode | input | 1 | 1: use internally generated bit clock and sync |
| linearMode | input | 1 | 0: 8-bit slots, 1: 16-bit slots |
| rxSlotA | input | 5 | Slot number of receive channel A |
| rxSlotB | input | 5 | Slot number of receive channel B |
| txSlot | input | 5 | Slot number of the transmit channel |
| txSample | input | 16 | Sample to transmit, captured at frame start |
| bclkIn | input | 1 | External bit clock |
| syncIn | input | 1 | External short-frame sync |
| serIn | input | 1 | Serial data in |
| bclkOut | output | 1 | Generated bit clock |
| syncOut | output | 1 | Generated frame sync |
| serOut | output | 1 | Serial data out |
| serOe | output | 1 | Output enable for serOut |
| rxDataA | output | 16 | Assembled sample of channel A |
| rxReadyA | output | 1 | One-cycle ready strobe of channel A |
| rxDataB | output | 16 | Assembled sample of channel B |
| rxReadyB | output | 1 | One-cycle ready strobe of channel B |

## Verification
Two pairs of events can fall in the same cycle: the two receive channels completing in the same slot, and the transmit drive landing in the slot a receive channel is capturing. One vector puts rxSlotA, rxSlotB and txSlot all on slot 7. The bench then checks that both strobes fire once with the same sample and that the transmit bits still match the sample latched at frame start. The frame-start latch also coincides with the first transmit bit when txSlot is 0. That case is judged by driving a different txSample in mid-frame and checking that the bits sent still match the value present at frame start.

// File: rtl/pcm_tdm_pkg.sv
`timescale 1ns/1ps
package pcm_tdm_pkg;
  localparam int FRAME_BITS = 256;
  localparam int SMP_W      = 16;
  localparam int NARROW_W   = 8;
  localparam int WIDE_W     = 16;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int CNT_W      = BIT_W + 1;
  localparam int NARROW_LG  = $clog2(NARROW_W);
  localparam int WIDE_LG    = $clog2(WIDE_W);
  localparam int SLOT_W     = BIT_W - NARROW_LG;
  localparam int IDX_W      = WIDE_LG;

  typedef struct packed {
    logic              load;
    logic              drive;
    logic              driveOn;
    logic [SLOT_W-1:0] driveSlot;
    logic [IDX_W-1:0]  driveIdx;
    logic              sample;
    logic [SLOT_W-1:0] sampSlot;
    logic [IDX_W-1:0]  sampIdx;
    logic              sampLast;
    logic              rxBit;
  } pcm_strobe_t;

  function automatic logic [SLOT_W-1:0] slotOf(input logic [BIT_W-1:0] b, input logic lin);
    return lin ? SLOT_W'(b >> WIDE_LG) : SLOT_W'(b >> NARROW_LG);
  endfunction

  function automatic logic [IDX_W-1:0] idxOf(input logic [BIT_W-1:0] b, input logic lin);
    return lin ? IDX_W'(b[WIDE_LG-1:0]) : IDX_W'(b[NARROW_LG-1:0]);
  endfunction

  function automatic logic isLast(input logic [IDX_W-1:0] k, input logic lin);
    return k == (lin ? IDX_W'(WIDE_W - 1) : IDX_W'(NARROW_W - 1));
  endfunction
endpackage

// File: rtl/pcm_bclk_gen.sv
`timescale 1ns/1ps
module pcm_bclk_gen
  import pcm_tdm_pkg::*;
#(
  parameter int HALF_DIV = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  output logic bclk,
  output logic sync
);
  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam logic [BIT_W-1:0] LAST_POS = BIT_W'(FRAME_BITS - 1);

  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitPos;
  logic [BIT_W-1:0] nextPos;

  assign nextPos = (bitPos == LAST_POS) ? '0 : bitPos + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      bclk   <= 1'b0;
      sync   <= 1'b0;
      bitPos <= LAST_POS;
    end else if (!enable) begin
      divCnt <= '0;
      bclk   <= 1'b0;
      sync   <= 1'b0;
      bitPos <= LAST_POS;
    end else if (divCnt == DIV_W'(HALF_DIV - 1)) begin
      divCnt <= '0;
      bclk   <= ~bclk;
      if (!bclk) begin
        bitPos <= nextPos;
        sync   <= (nextPos == LAST_POS);
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_tdm_ctrl.sv
`timescale 1ns/1ps
module pcm_tdm_ctrl
  import pcm_tdm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        powerDown,
  input  logic        linearMode,
  input  logic        bclkSrc,
  input  logic        syncSrc,
  input  logic        serInSrc,
  output pcm_strobe_t stb
);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(FRAME_BITS);

  logic             bclkR, bclkQ, syncR, serInR;
  logic             syncSeen, framed;
  logic [CNT_W-1:0] curBit;
  logic [CNT_W-1:0] nextBit;
  logic             rise, fall;

  assign rise = bclkR & ~bclkQ;
  assign fall = ~bclkR & bclkQ;

  always_comb begin
    if (syncSeen)              nextBit = '0;
    else if (curBit == END_CNT) nextBit = curBit;
    else                       nextBit = curBit + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkR    <= 1'b0;
      bclkQ    <= 1'b0;
      syncR    <= 1'b0;
      serInR   <= 1'b0;
      syncSeen <= 1'b0;
      framed   <= 1'b0;
      curBit   <= END_CNT;
    end else if (powerDown) begin
      bclkR    <= 1'b0;
      bclkQ    <= 1'b0;
      syncR    <= 1'b0;
      serInR   <= 1'b0;
      syncSeen <= 1'b0;
      framed   <= 1'b0;
      curBit   <= END_CNT;
    end else begin
      bclkR  <= bclkSrc;
      bclkQ  <= bclkR;
      syncR  <= syncSrc;
      serInR <= serInSrc;
      if (fall && syncR) syncSeen <= 1'b1;
      if (rise) begin
        curBit <= nextBit;
        if (syncSeen) begin
          framed   <= 1'b1;
          syncSeen <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    stb.load      = rise & syncSeen;
    stb.drive     = rise;
    stb.driveOn   = (syncSeen | framed) & (nextBit < END_CNT);
    stb.driveSlot = slotOf(nextBit[BIT_W-1:0], linearMode);
    stb.driveIdx  = idxOf(nextBit[BIT_W-1:0], linearMode);
    stb.sample    = fall & framed & (curBit < END_CNT);
    stb.sampSlot  = slotOf(curBit[BIT_W-1:0], linearMode);
    stb.sampIdx   = idxOf(curBit[BIT_W-1:0], linearMode);
    stb.sampLast  = isLast(stb.sampIdx, linearMode);
    stb.rxBit     = serInR;
  end
endmodule

// File: rtl/pcm_tdm_datapath.sv
`timescale 1ns/1ps
module pcm_tdm_datapath
  import pcm_tdm_pkg::*;
#(
  parameter int NUM_RX = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          powerDown,
  input  logic                          linearMode,
  input  pcm_strobe_t                   stb,
  input  logic [NUM_RX-1:0][SLOT_W-1:0] rxSlot,
  input  logic [SLOT_W-1:0]             txSlot,
  input  logic [SMP_W-1:0]              txSample,
  output logic                          serOut,
  output logic                          serOe,
  output logic [NUM_RX-1:0][SMP_W-1:0]  rxData,
  output logic [NUM_RX-1:0]             rxReady
);
  logic [SMP_W-1:0] txHold;
  logic [SMP_W-1:0] txNow;
  logic             txHit;
  logic [IDX_W-1:0] bitSel;

  assign txNow  = stb.load ? txSample : txHold;
  assign txHit  = stb.driveOn & (stb.driveSlot == txSlot);
  assign bitSel = linearMode ? (IDX_W'(WIDE_W - 1) - stb.driveIdx)
                             : (IDX_W'(NARROW_W - 1) - stb.driveIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold <= '0;
      serOut <= 1'b0;
      serOe  <= 1'b0;
    end else if (powerDown) begin
      txHold <= '0;
      serOut <= 1'b0;
      serOe  <= 1'b0;
    end else if (stb.drive) begin
      if (stb.load) txHold <= txSample;
      serOe  <= txHit;
      serOut <= txHit & txNow[bitSel];
    end
  end

  for (genvar ch = 0; ch < NUM_RX; ch++) begin : g_rx
    logic [SMP_W-1:0] shiftReg;
    logic             hit;
    assign hit = stb.sample & (stb.sampSlot == rxSlot[ch]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shiftReg    <= '0;
        rxData[ch]  <= '0;
        rxReady[ch] <= 1'b0;
      end else if (powerDown) begin
        shiftReg    <= '0;
        rxData[ch]  <= '0;
        rxReady[ch] <= 1'b0;
      end else begin
        rxReady[ch] <= 1'b0;
        if (hit) begin
          if (stb.sampIdx == '0) shiftReg <= {{(SMP_W-1){1'b0}}, stb.rxBit};
          else                   shiftReg <= {shiftReg[SMP_W-2:0], stb.rxBit};
          if (stb.sampLast) begin
            rxData[ch]  <= {shiftReg[SMP_W-2:0], stb.rxBit};
            rxReady[ch] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pcm_tdm_port.sv
`timescale 1ns/1ps
module pcm_tdm_port
  import pcm_tdm_pkg::*;
#(
  parameter int HALF_DIV = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        powerDown,
  input  logic        masterMode,
  input  logic        linearMode,
  input  logic [4:0]  rxSlotA,
  input  logic [4:0]  rxSlotB,
  input  logic [4:0]  txSlot,
  input  logic [15:0] txSample,
  input  logic        bclkIn,
  input  logic        syncIn,
  input  logic        serIn,
  output logic        bclkOut,
  output logic        syncOut,
  output logic        serOut,
  output logic        serOe,
  output logic [15:0] rxDataA,
  output logic        rxReadyA,
  output logic [15:0] rxDataB,
  output logic        rxReadyB
);
  pcm_strobe_t              stb;
  logic [1:0][SLOT_W-1:0]   rxSlotVec;
  logic [1:0][SMP_W-1:0]    rxDataVec;
  logic [1:0]               rxReadyVec;

  pcm_bclk_gen #(.HALF_DIV(HALF_DIV)) u_gen (
    .clk    (clk),
    .rstN   (rstN),
    .enable (masterMode & ~powerDown),
    .bclk   (bclkOut),
    .sync   (syncOut)
  );

  pcm_tdm_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .powerDown  (powerDown),
    .linearMode (linearMode),
    .bclkSrc    (masterMode ? bclkOut : bclkIn),
    .syncSrc    (masterMode ? syncOut : syncIn),
    .serInSrc   (serIn),
    .stb        (stb)
  );

  assign rxSlotVec = {rxSlotB, rxSlotA};

  pcm_tdm_datapath #(.NUM_RX(2)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .powerDown  (powerDown),
    .linearMode (linearMode),
    .stb        (stb),
    .rxSlot     (rxSlotVec),
    .txSlot     (txSlot),
    .txSample   (txSample),
    .serOut     (serOut),
    .serOe      (serOe),
    .rxData     (rxDataVec),
    .rxReady    (rxReadyVec)
  );

  assign rxDataA  = rxDataVec[0];
  assign rxDataB  = rxDataVec[1];
  assign rxReadyA = rxReadyVec[0];
  assign rxReadyB = rxReadyVec[1];
endmodule

// File: rtl/pcm_tdm_port_chk.sv
`timescale 1ns/1ps
module pcm_tdm_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic        powerDown,
  input logic        masterMode,
  input logic        bclkOut,
  input logic        syncOut,
  input logic        serOut,
  input logic        serOe,
  input logic [15:0] rxDataA,
  input logic        rxReadyA,
  input logic [15:0] rxDataB,
  input logic        rxReadyB
);
  p_pd_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> (!serOe && !bclkOut && !syncOut && !rxReadyA && !rxReadyB));

  p_ready_single_a_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxReadyA |=> !rxReadyA);

  p_ready_single_b_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxReadyB |=> !rxReadyB);

  p_hold_a_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!rxReadyA && !$past(powerDown)) |-> $stable(rxDataA));

  p_hold_b_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!rxReadyB && !$past(powerDown)) |-> $stable(rxDataB));

  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !serOe |-> !serOut);

  p_sync_edge_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOut) |-> $rose(bclkOut));

  p_slave_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |=> (!bclkOut && !syncOut));
endmodule

bind pcm_tdm_port pcm_tdm_port_chk u_chk (.*);

// File: tb/pcm_tdm_port_test.sv
`timescale 1ns/1ps
module pcm_tdm_port_test;
  localparam int HALF = 6;
  localparam int NV = 10;

  typedef struct packed {
    logic        lin;
    logic [4:0]  sa;
    logic [4:0]  sb;
    logic [4:0]  st;
    logic [15:0] tx;
    logic [15:0] va;
    logic [15:0] vb;
    logic [8:0]  nb;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'd0,  5'd31, 5'd5,  16'h00A5, 16'h003C, 16'h00C3, 9'd256},
    '{1'b0, 5'd31, 5'd1,  5'd0,  16'h0081, 16'h0080, 16'h0001, 9'd256},
    '{1'b0, 5'd7,  5'd7,  5'd7,  16'h005A, 16'h00E7, 16'h0000, 9'd256},
    '{1'b0, 5'd2,  5'd3,  5'd31, 16'hFFFF, 16'h0000, 16'h00FF, 9'd256},
    '{1'b1, 5'd0,  5'd15, 5'd8,  16'hBEEF, 16'h1234, 16'h8001, 9'd256},
    '{1'b1, 5'd15, 5'd3,  5'd15, 16'h8001, 16'hFFFF, 16'h5555, 9'd256},
    '{1'b1, 5'd16, 5'd4,  5'd20, 16'h1111, 16'hAAAA, 16'h0F0F, 9'd256},
    '{1'b0, 5'd7,  5'd8,  5'd6,  16'h0033, 16'h0096, 16'h0011, 9'd64},
    '{1'b1, 5'd1,  5'd0,  5'd0,  16'h7FFE, 16'h4321, 16'h0001, 9'd32},
    '{1'b0, 5'd4,  5'd5,  5'd3,  16'h00C6, 16'h005B, 16'h00A4, 9'd256}
  };

  logic clk = 1'b0;
  logic rstN, powerDown, masterMode, linearMode;
  logic [4:0] rxSlotA, rxSlotB, txSlot;
  logic [15:0] txSample;
  logic bclkIn, syncIn, serIn;
  logic bclkOut, syncOut, serOut, serOe, rxReadyA, rxReadyB;
  logic [15:0] rxDataA, rxDataB;

  int nChk = 0;
  int nFail = 0;
  int totA = 0, totB = 0;
  logic [15:0] lastA = '0, lastB = '0;

  always #5 clk = ~clk;

  pcm_tdm_port #(.HALF_DIV(HALF)) uut (.*);

  always @(posedge clk) begin
    if (rxReadyA) begin totA <= totA + 1; lastA <= rxDataA; end
    if (rxReadyB) begin totB <= totB + 1; lastB <= rxDataB; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doBit(input logic s, input logic d, output logic oeS, output logic outS);
    @(negedge clk);
    bclkIn = 1'b1; serIn = d; syncIn = s;
    repeat (7) @(negedge clk);
    oeS = serOe; outS = serOut;
    @(negedge clk);
    bclkIn = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  task automatic runVec(input vec_t v);
    int w, oeCnt, firstOe, idleHigh, sA, sB, expA, expB, expCntA, expCntB, expOe, expTx;
    logic [15:0] txGot;
    logic oeS, outS, d;
    string sTag;
    w = v.lin ? 16 : 8;
    sTag = v.lin ? "R4" : "R3";
    linearMode = v.lin; rxSlotA = v.sa; rxSlotB = v.sb; txSlot = v.st;
    txSample = v.tx;
    sA = totA; sB = totB;
    oeCnt = 0; firstOe = -1; idleHigh = 0; txGot = '0;
    for (int b = 0; b < int'(v.nb); b++) begin
      int slot, k;
      slot = b / w; k = b % w;
      if (slot == int'(v.sa))      d = v.va[w-1-k];
      else if (slot == int'(v.sb)) d = v.vb[w-1-k];
      else                         d = logic'((b % 3) == 1);
      if (b == 2) txSample = ~v.tx;
      doBit(b == int'(v.nb) - 1, d, oeS, outS);
      if (oeS) begin
        oeCnt++;
        if (oeCnt == 1) firstOe = b;
        txGot = {txGot[14:0], outS};
      end else if (outS) idleHigh++;
    end
    repeat (4) @(negedge clk);
    expA = v.lin ? int'(v.va) : int'(v.va[7:0]);
    expB = (v.sb == v.sa) ? expA : (v.lin ? int'(v.vb) : int'(v.vb[7:0]));
    expCntA = (int'(v.sa) * w + w <= int'(v.nb)) ? 1 : 0;
    expCntB = (int'(v.sb) * w + w <= int'(v.nb)) ? 1 : 0;
    expOe   = (int'(v.st) * w + w <= int'(v.nb)) ? w : 0;
    expTx   = v.lin ? int'(v.tx) : int'(v.tx[7:0]);
    chk(totA - sA == expCntA, {sTag, "/R6 ready count A"}, totA - sA, expCntA);
    chk(totB - sB == expCntB, {sTag, "/R7 ready count B"}, totB - sB, expCntB);
    if (expCntA == 1) chk(int'(lastA) == expA, "R5 rxDataA", int'(lastA), expA);
    if (expCntB == 1) chk(int'(lastB) == expB, "R7 rxDataB", int'(lastB), expB);
    chk(oeCnt == expOe, {sTag, "/R8 serOe bit count"}, oeCnt, expOe);
    chk(idleHigh == 0, "R8 serOut high while disabled", idleHigh, 0);
    if (expOe != 0) begin
      chk(firstOe == int'(v.st) * w, "R8 first driven bit", firstOe, int'(v.st) * w);
      chk((v.lin ? int'(txGot) : int'(txGot[7:0])) == expTx, "R9 transmitted sample",
          v.lin ? int'(txGot) : int'(txGot[7:0]), expTx);
    end
    if (v.nb != 9'd256) chk(totA - sA == expCntA, "R2 short frame restart", totA - sA, expCntA);
  endtask

  initial begin
    #1500000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic oeS, outS;
    int cnt, viol, n;
    logic prev;
    rstN = 1'b0; powerDown = 1'b0; masterMode = 1'b0; linearMode = 1'b0;
    rxSlotA = '0; rxSlotB = '0; txSlot = '0; txSample = 16'hFFFF;
    bclkIn = 1'b0; syncIn = 1'b0; serIn = 1'b0;
    repeat (5) @(negedge clk);
    chk(serOe == 0 && serOut == 0, "R1 serial outputs in reset", {serOe, serOut}, 0);
    chk(rxReadyA == 0 && rxReadyB == 0, "R1 strobes in reset", {rxReadyA, rxReadyB}, 0);
    chk(rxDataA == 0 && rxDataB == 0, "R1 sample outputs in reset", int'(rxDataA | rxDataB), 0);
    chk(bclkOut == 0 && syncOut == 0, "R1 clock outputs in reset", {bclkOut, syncOut}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    cnt = 0;
    for (int b = 0; b < 12; b++) begin
      doBit(1'b0, 1'b1, oeS, outS);
      if (oeS) cnt++;
    end
    chk(cnt == 0, "R2 no drive before first sync", cnt, 0);
    chk(totA == 0 && totB == 0, "R2 no strobe before first sync", totA + totB, 0);

    doBit(1'b1, 1'b0, oeS, outS);
    for (int i = 0; i < NV; i++) runVec(VECS[i]);

    masterMode = 1'b1;
    prev = syncOut; n = 0;
    while (!(syncOut && !prev) && n < 10000) begin prev = syncOut; @(negedge clk); n++; end
    cnt = 0;
    while (bclkOut) begin cnt++; @(negedge clk); end
    chk(cnt == HALF, "R10 bclkOut high phase", cnt, HALF);
    n = cnt; viol = 0; prev = syncOut;
    while (!(syncOut && !prev) && n < 10000) begin
      if (syncOut) viol++;
      prev = syncOut; @(negedge clk); n++;
    end
    chk(n == 256 * 2 * HALF, "R10 frame period", n, 256 * 2 * HALF);
    chk(viol + (n > 0 ? 0 : 0) <= 2 * HALF && viol >= 2 * HALF - HALF, "R10 sync width", viol, 2 * HALF - cnt);

    powerDown = 1'b1;
    repeat (2) @(negedge clk);
    viol = 0;
    for (int c = 0; c < 40; c++) begin
      if (bclkOut || syncOut || serOe) viol++;
      @(negedge clk);
    end
    chk(viol == 0, "R11 outputs low in power-down", viol, 0);
    chk(rxDataA == 0 && rxDataB == 0, "R11 samples cleared", int'(rxDataA | rxDataB), 0);
    masterMode = 1'b0; linearMode = 1'b0; rxSlotA = 5'd0; rxSlotB = 5'd1; txSlot = 5'd0;
    n = totA + totB; cnt = 0;
    doBit(1'b1, 1'b1, oeS, outS);
    for (int b = 0; b < 24; b++) begin
      doBit(1'b0, 1'b1, oeS, outS);
      if (oeS) cnt++;
    end
    chk(totA + totB == n && cnt == 0, "R11 no activity in power-down", totA + totB - n + cnt, 0);
    powerDown = 1'b0;
    repeat (3) @(negedge clk);
    cnt = 0;
    for (int b = 0; b < 16; b++) begin
      doBit(1'b0, 1'b1, oeS, outS);
      if (oeS) cnt++;
    end
    chk(cnt == 0 && totA + totB == n, "R11 waits for sync after release", cnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule